// File: doc/BRIEF.md
# Receive Buffer Ring Manager

This block keeps track of where incoming frames may be placed in memory. The host builds a circular table of buffer descriptors in memory. Each descriptor is four 16-bit words: a 32-bit buffer base address followed by a 32-bit buffer size counted in 16-bit words. The host then programs four pointers that describe this table: the ring start, the ring end, the read position and the write position. It can also program an end-of-buffer threshold. The host starts a fetch by command. The block reads the descriptor at the read position into its current-buffer registers, moves the read position one entry forward with wrap-around, and raises an early warning when the read position has caught up with the write position.

For every frame the receive path offers, the block computes the stored length: the frame bytes plus four CRC bytes, rounded up to the bus granule. It then either charges that length against the current buffer or rejects the frame as too large. After the frame it decides one of three things: keep the buffer, move to the next descriptor automatically, or stop reception until the host fetches again. A single mode input selects 16-bit or 32-bit descriptor spacing. That input governs pointer alignment, fetch address stride, read-pointer step and rounding granule.

Top module: `rxr_ring_mgr`

## Requirements
- R1: A fetch issues four single-word memory reads at read_ptr + i*S for i = 0..3, where S is 2 bytes in 16-bit mode and 4 bytes in 32-bit mode. The words, in order, load buf_addr[15:0], buf_addr[31:16], words_left[15:0] and words_left[31:16].
- R2: When a fetch completes, read_ptr advances by 8 (16-bit mode) or 16 (32-bit mode). If the result equals ring_end, read_ptr takes ring_start instead.
- R3: If read_ptr equals wr_ptr once a fetch has completed, sts_exhaust is set. A pulse on ack_exhaust clears it.
- R4: Host writes through reg_sel (0 = ring start, 1 = ring end, 2 = read pointer, 3 = write pointer, 4 = end-of-buffer threshold) are masked with 0xFFFE in 16-bit mode and 0xFFFC in 32-bit mode for selects 0 to 3. The threshold is stored unmasked.
- R5: ack_exhaust starts a fetch only while sts_exhaust is set. While sts_exhaust is clear, it leaves read_ptr and the memory port untouched.
- R6: An accepted frame of L bytes has stored length P = L+4 rounded up to a multiple of 4 (32-bit mode) or 2 (16-bit mode). When P is at most 2*words_left, the next cycle shows words_left reduced by P/2, buf_addr increased by P, and a one-cycle frm_stored pulse.
- R7: When P exceeds 2*words_left, the next cycle shows frm_overflow pulsed and sts_area and last_pkt set, with words_left and buf_addr unchanged. ack_area clears sts_area.
- R8: After a stored frame, last_pkt is set exactly when the remaining word count is below the end-of-buffer threshold. Each accepted frame rewrites last_pkt.
- R9: When a frame sets last_pkt, reception stops (stopped = 1) if read_ptr equals wr_ptr. Otherwise a fetch starts automatically in the next cycle.
- R10: A completed fetch clears stopped.
- R11: accept is low while stopped or while a fetch is in progress. A frame offered while accept is low changes no counter, address or flag.
- R12: Reset clears all pointers, buf_addr, words_left and flags, sets the threshold to 0x02F8, and leaves accept high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1 selects 32-bit descriptor spacing, 0 selects 16-bit |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select (see R4) |
| reg_wdata | input | 16 | Host write data |
| fetch_cmd | input | 1 | Command pulse: fetch next descriptor |
| ack_exhaust | input | 1 | Write-one-to-clear of sts_exhaust |
| ack_area | input | 1 | Write-one-to-clear of sts_area |
| mem_req | output | 1 | Memory read request, held until mem_valid |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_rdata | input | 16 | Returned memory word |
| mem_valid | input | 1 | Memory word valid |
| frm_valid | input | 1 | Receive path offers a frame |
| frm_len | input | 16 | Frame length in bytes, CRC excluded |
| accept | output | 1 | Block can take a frame this cycle |
| frm_stored | output | 1 | Pulse: last frame was charged to the buffer |
| frm_overflow | output | 1 | Pulse: last frame did not fit |
| buf_addr | output | 32 | Current write address in the receive buffer |
| words_left | output | 32 | Remaining 16-bit words in the buffer |
| ring_start | output | 16 | Ring start pointer |
| ring_end | output | 16 | Ring end pointer |
| rd_ptr | output | 16 | Descriptor read pointer |
| wr_ptr | output | 16 | Descriptor write pointer |
| eob_thresh | output | 16 | End-of-buffer threshold in words |
| sts_exhaust | output | 1 | Ring nearly exhausted status |
| sts_area | output | 1 | Frame exceeded buffer area status |
| last_pkt | output | 1 | Last frame ended the buffer |
| stopped | output | 1 | Reception halted until next fetch |

## Verification
The bench sweeps every frame length from 1 to 100 bytes in both spacing modes. This exercises the rounding at each granule edge, the exact boundary between a frame that just fits and one that overflows, and the threshold comparison on each side. A rounding slip or an off-by-one in the fit test would show up there as a wrong word count or a wrongly flagged overflow. Directed cases then force the read pointer onto the ring end, so a missing wrap would leave read_ptr at the end address. They align it with the write pointer so the warning and the stop condition must fire, and a design that skipped the equality test would keep accepting. They acknowledge the warning both while it is set and while it is clear, so an unconditional refetch would move read_ptr. Finally a frame is offered while stopped, and a design that still charged it would change words_left.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  parameter int PTR_W = 16;
  parameter int CNT_W = 32;
  parameter int LEN_W = 16;
  parameter int DESC_WORDS = 4;
  localparam int PAD_W = LEN_W + 1;

  typedef enum logic [2:0] {
    SEL_START = 3'd0,
    SEL_END   = 3'd1,
    SEL_RD    = 3'd2,
    SEL_WR    = 3'd3,
    SEL_EOB   = 3'd4
  } reg_sel_e;

  // Stored length: frame + CRC, rounded up to the bus granule.
  function automatic logic [PAD_W-1:0] pad_bytes(input logic [LEN_W-1:0] len,
                                                  input logic wide);
    logic [PAD_W-1:0] raw;
    logic [PAD_W-1:0] gmask;
    raw   = {1'b0, len} + PAD_W'(4);
    gmask = wide ? PAD_W'(3) : PAD_W'(1);
    return ((raw - PAD_W'(1)) | gmask) + PAD_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_mask(input logic wide);
    return wide ? {{(PTR_W-2){1'b1}}, 2'b00} : {{(PTR_W-1){1'b1}}, 1'b0};
  endfunction

  // Distance between two descriptor entries.
  function automatic logic [PTR_W-1:0] entry_step(input logic wide);
    return wide ? PTR_W'(16) : PTR_W'(8);
  endfunction

  // Distance between two words of one descriptor.
  function automatic logic [PTR_W-1:0] word_stride(input logic wide);
    return wide ? PTR_W'(4) : PTR_W'(2);
  endfunction
endpackage

// File: rtl/rxr_ptr_bank.sv
module rxr_ptr_bank
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             wr_en,
  input  logic [2:0]       sel,
  input  logic [PTR_W-1:0] wdata,
  input  logic             adv,
  output logic [PTR_W-1:0] start_o,
  output logic [PTR_W-1:0] end_o,
  output logic [PTR_W-1:0] rd_o,
  output logic [PTR_W-1:0] wr_o,
  output logic [PTR_W-1:0] eob_o,
  output logic             adv_hits_wr
);
  localparam int NPTR = 4;
  localparam logic [PTR_W-1:0] EOB_RST = PTR_W'(16'h02F8);

  logic [PTR_W-1:0] ptr_q [NPTR];
  logic [PTR_W-1:0] eob_q;
  logic [PTR_W-1:0] rd_raw;
  logic [PTR_W-1:0] rd_adv;

  assign rd_raw      = ptr_q[SEL_RD] + entry_step(wide);
  assign rd_adv      = (rd_raw == ptr_q[SEL_END]) ? ptr_q[SEL_START] : rd_raw;
  assign adv_hits_wr = (rd_adv == ptr_q[SEL_WR]);

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[gi] <= '0;
      end else if ((gi == int'(SEL_RD)) && adv) begin
        ptr_q[gi] <= rd_adv;
      end else if (wr_en && (sel == 3'(gi))) begin
        ptr_q[gi] <= wdata & ptr_mask(wide);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eob_q <= EOB_RST;
    end else if (wr_en && (sel == SEL_EOB)) begin
      eob_q <= wdata;
    end
  end

  assign start_o = ptr_q[SEL_START];
  assign end_o   = ptr_q[SEL_END];
  assign rd_o    = ptr_q[SEL_RD];
  assign wr_o    = ptr_q[SEL_WR];
  assign eob_o   = eob_q;
endmodule

// File: rtl/rxr_fetch_seq.sv
module rxr_fetch_seq
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             start,
  input  logic [PTR_W-1:0] base,
  output logic             mem_req,
  output logic [PTR_W-1:0] mem_addr,
  input  logic [15:0]      mem_rdata,
  input  logic             mem_valid,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] ld_addr,
  output logic [CNT_W-1:0] ld_words
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [PTR_W-1:0] base_q;
  logic [15:0]      word_q [DESC_WORDS-1];

  assign busy     = busy_q;
  assign mem_req  = busy_q;
  assign mem_addr = base_q + PTR_W'(idx_q) * word_stride(wide);
  assign done     = busy_q && mem_valid && (idx_q == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        base_q <= base;
      end
    end else if (mem_valid) begin
      idx_q <= idx_q + IDX_W'(1);
      if (idx_q == IDX_LAST) busy_q <= 1'b0;
    end
  end

  for (genvar gw = 0; gw < DESC_WORDS - 1; gw++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[gw] <= '0;
      end else if (busy_q && mem_valid && (idx_q == IDX_W'(gw))) begin
        word_q[gw] <= mem_rdata;
      end
    end
  end

  assign ld_addr  = {word_q[1], word_q[0]};
  assign ld_words = {mem_rdata, word_q[2]};
endmodule

// File: rtl/rxr_space_acct.sv
module rxr_space_acct
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_addr,
  input  logic [CNT_W-1:0] ld_words,
  input  logic             take,
  input  logic [LEN_W-1:0] len,
  input  logic [PTR_W-1:0] eob,
  output logic [CNT_W-1:0] buf_addr,
  output logic [CNT_W-1:0] words_left,
  output logic             stored_q,
  output logic             ovf_q,
  output logic             oversize,
  output logic             frame_last
);
  logic [PAD_W-1:0] pad;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] addr_q;
  logic [CNT_W-1:0] words_q;

  assign pad        = pad_bytes(len, wide);
  assign oversize   = {{(CNT_W+1-PAD_W){1'b0}}, pad} > {words_q, 1'b0};
  assign remain     = words_q - CNT_W'(pad[PAD_W-1:1]);
  assign frame_last = oversize || (remain < CNT_W'(eob));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      words_q  <= '0;
      stored_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      stored_q <= take && !oversize;
      ovf_q    <= take && oversize;
      if (load) begin
        addr_q  <= ld_addr;
        words_q <= ld_words;
      end else if (take && !oversize) begin
        addr_q  <= addr_q + CNT_W'(pad);
        words_q <= remain;
      end
    end
  end

  assign buf_addr   = addr_q;
  assign words_left = words_q;
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [15:0]      reg_wdata,
  input  logic             fetch_cmd,
  input  logic             ack_exhaust,
  input  logic             ack_area,
  output logic             mem_req,
  output logic [15:0]      mem_addr,
  input  logic [15:0]      mem_rdata,
  input  logic             mem_valid,
  input  logic             frm_valid,
  input  logic [15:0]      frm_len,
  output logic             accept,
  output logic             frm_stored,
  output logic             frm_overflow,
  output logic [31:0]      buf_addr,
  output logic [31:0]      words_left,
  output logic [15:0]      ring_start,
  output logic [15:0]      ring_end,
  output logic [15:0]      rd_ptr,
  output logic [15:0]      wr_ptr,
  output logic [15:0]      eob_thresh,
  output logic             sts_exhaust,
  output logic             sts_area,
  output logic             last_pkt,
  output logic             stopped
);
  // Named internal events, brought out for the checker.
  logic             fetch_busy;
  logic             fetch_done;
  logic             fetch_start;
  logic             fetch_want;
  logic             frame_take;
  logic             frame_last;
  logic             frame_oversize;
  logic             ring_caught;
  logic             adv_hits_wr;
  logic [CNT_W-1:0] ld_addr;
  logic [CNT_W-1:0] ld_words;

  logic stopped_q, exh_q, area_q, last_q;

  assign accept      = !stopped_q && !fetch_busy;
  assign frame_take  = frm_valid && accept;
  assign ring_caught = (rd_ptr == wr_ptr);
  assign fetch_want  = fetch_cmd
                    || (ack_exhaust && exh_q)
                    || (frame_take && frame_last && !ring_caught);
  assign fetch_start = fetch_want && !fetch_busy;

  rxr_ptr_bank u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide       (wide_mode),
    .wr_en      (reg_wr),
    .sel        (reg_sel),
    .wdata      (reg_wdata),
    .adv        (fetch_done),
    .start_o    (ring_start),
    .end_o      (ring_end),
    .rd_o       (rd_ptr),
    .wr_o       (wr_ptr),
    .eob_o      (eob_thresh),
    .adv_hits_wr(adv_hits_wr)
  );

  rxr_fetch_seq u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (wide_mode),
    .start    (fetch_start),
    .base     (rd_ptr),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata),
    .mem_valid(mem_valid),
    .busy     (fetch_busy),
    .done     (fetch_done),
    .ld_addr  (ld_addr),
    .ld_words (ld_words)
  );

  rxr_space_acct u_space (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide      (wide_mode),
    .load      (fetch_done),
    .ld_addr   (ld_addr),
    .ld_words  (ld_words),
    .take      (frame_take),
    .len       (frm_len),
    .eob       (eob_thresh),
    .buf_addr  (buf_addr),
    .words_left(words_left),
    .stored_q  (frm_stored),
    .ovf_q     (frm_overflow),
    .oversize  (frame_oversize),
    .frame_last(frame_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q <= 1'b0;
      exh_q     <= 1'b0;
      area_q    <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      if (fetch_done) begin
        stopped_q <= 1'b0;
      end else if (frame_take && frame_last && ring_caught) begin
        stopped_q <= 1'b1;
      end

      if (fetch_done && adv_hits_wr) begin
        exh_q <= 1'b1;
      end else if (ack_exhaust) begin
        exh_q <= 1'b0;
      end

      if (frame_take && frame_oversize) begin
        area_q <= 1'b1;
      end else if (ack_area) begin
        area_q <= 1'b0;
      end

      if (frame_take) last_q <= frame_last;
    end
  end

  assign stopped     = stopped_q;
  assign sts_exhaust = exh_q;
  assign sts_area    = area_q;
  assign last_pkt    = last_q;
endmodule

// File: rtl/rxr_ring_mgr_chk.sv
module rxr_ring_mgr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        mem_req,
  input logic        stopped,
  input logic        frm_valid,
  input logic        frm_stored,
  input logic        frm_overflow,
  input logic        sts_area,
  input logic        sts_exhaust,
  input logic        last_pkt,
  input logic [31:0] words_left,
  input logic [15:0] rd_ptr,
  input logic [15:0] wr_ptr,
  input logic        fetch_done
);
  AST_BUSY_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !accept); // R11
  AST_STOP_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !accept); // R11
  AST_STORE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_stored |-> $past(frm_valid && accept)); // R6
  AST_OVF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_overflow |-> (sts_area && last_pkt)); // R7
  AST_OVF_KEEPS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_overflow |-> $stable(words_left)); // R7
  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr[0] == 1'b0); // R4
  AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> (last_pkt && rd_ptr == wr_ptr)); // R9
  AST_EXH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_exhaust) |-> (rd_ptr == wr_ptr)); // R3
  AST_DONE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !stopped); // R10
endmodule

bind rxr_ring_mgr rxr_ring_mgr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .mem_req     (mem_req),
  .stopped     (stopped),
  .frm_valid   (frm_valid),
  .frm_stored  (frm_stored),
  .frm_overflow(frm_overflow),
  .sts_area    (sts_area),
  .sts_exhaust (sts_exhaust),
  .last_pkt    (last_pkt),
  .words_left  (words_left),
  .rd_ptr      (rd_ptr),
  .wr_ptr      (wr_ptr),
  .fetch_done  (fetch_done)
);

// File: tb/rxr_ring_mgr_tb.sv
`timescale 1ns/1ps
module rxr_ring_mgr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        fetch_cmd = 1'b0;
  logic        ack_exhaust = 1'b0;
  logic        ack_area = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        mem_valid = 1'b0;
  logic        frm_valid = 1'b0;
  logic [15:0] frm_len = '0;
  logic        accept, frm_stored, frm_overflow;
  logic [31:0] buf_addr, words_left;
  logic [15:0] ring_start, ring_end, rd_ptr, wr_ptr, eob_thresh;
  logic        sts_exhaust, sts_area, last_pkt, stopped;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic finished = 1'b0;
  logic [15:0] bmem [128];

  always #2 clk = ~clk;

  rxr_ring_mgr dut_i (.*);

  always @(negedge clk) begin
    mem_valid <= mem_req;
    mem_rdata <= bmem[mem_addr[7:1]];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !finished) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [15:0] v);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20; k++) begin
      if (!mem_req) break;
      tick();
    end
  endtask

  task automatic do_fetch();
    fetch_cmd = 1'b1;
    tick();
    fetch_cmd = 1'b0;
    wait_idle();
  endtask

  task automatic do_frame(input int len);
    frm_valid = 1'b1; frm_len = 16'(len);
    tick();
    frm_valid = 1'b0;
  endtask

  // Four descriptors from 0x20; word i of entry k at base + i*g.
  task automatic fill(input int g);
    for (int k = 0; k < 128; k++) bmem[k] = 16'hDEAD;
    for (int k = 0; k < 4; k++) begin
      int base;
      base = 32 + k * 4 * g;
      bmem[base >> 1]         = 16'(32'h1000 + base);
      bmem[(base + g) >> 1]   = 16'h0001;
      bmem[(base + 2*g) >> 1] = 16'd40;
      bmem[(base + 3*g) >> 1] = 16'h0000;
    end
  endtask

  initial begin
    int rd_m, g, step, ring_e;
    fill(2);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R12 reset state
    chk(eob_thresh == 16'h02F8, "R12 eob reset", eob_thresh, 16'h02F8);
    chk(accept && !stopped && !mem_req, "R12 accept at reset", {accept, stopped, mem_req}, 3'b100);
    chk(words_left == 0 && buf_addr == 0 && rd_ptr == 0, "R12 counters reset", words_left, 0);
    chk(!sts_exhaust && !sts_area && !last_pkt, "R12 flags reset", {sts_exhaust, sts_area, last_pkt}, 0);

    // R4 masking in both modes
    for (int m = 0; m < 2; m++) begin
      logic [15:0] mexp;
      wide_mode = m[0];
      mexp = m[0] ? 16'hFFFC : 16'hFFFE;
      for (int s = 0; s < 4; s++) wr_reg(3'(s), 16'hFFFF);
      chk(ring_start == mexp, "R4 start mask", ring_start, mexp);
      chk(ring_end == mexp, "R4 end mask", ring_end, mexp);
      chk(rd_ptr == mexp, "R4 read mask", rd_ptr, mexp);
      chk(wr_ptr == mexp, "R4 write mask", wr_ptr, mexp);
    end
    wr_reg(3'd4, 16'hFFFF);
    chk(eob_thresh == 16'hFFFF, "R4 threshold unmasked", eob_thresh, 16'hFFFF);

    // Sweep of frame lengths in both modes (R1 R2 R6 R7 R8 R9)
    for (int m = 0; m < 2; m++) begin
      wide_mode = m[0];
      g = m[0] ? 4 : 2;
      step = 4 * g;
      ring_e = 32 + 4 * step;
      fill(g);
      wr_reg(3'd0, 16'h0020);
      wr_reg(3'd1, 16'(ring_e));
      wr_reg(3'd2, 16'h0020);
      wr_reg(3'd3, 16'h0010);
      wr_reg(3'd4, 16'd20);
      rd_m = 32;
      for (int len = 1; len <= 100; len++) begin
        int pad, base;
        base = rd_m;
        do_fetch();
        rd_m = rd_m + step;
        if (rd_m == ring_e) rd_m = 32;
        chk(buf_addr == 32'h00010000 + 32'h1000 + 32'(base), "R1 descriptor address", buf_addr, 32'h00011000 + base);
        chk(words_left == 40, "R1 descriptor count", words_left, 40);
        chk(rd_ptr == 16'(rd_m), "R2 read advance", rd_ptr, rd_m);
        pad = ((len + 4 + g - 1) / g) * g;
        do_frame(len);
        if (pad > 80) begin
          chk(frm_overflow && !frm_stored, "R7 overflow pulse", {frm_overflow, frm_stored}, 2'b10);
          chk(words_left == 40 && buf_addr == 32'h00011000 + 32'(base), "R7 nothing charged", words_left, 40);
          chk(sts_area && last_pkt, "R7 area and last", {sts_area, last_pkt}, 2'b11);
          chk(mem_req, "R9 auto fetch after overflow", mem_req, 1);
          wait_idle();
          rd_m = rd_m + step;
          if (rd_m == ring_e) rd_m = 32;
          ack_area = 1'b1; tick(); ack_area = 1'b0;
          chk(!sts_area, "R7 area clears", sts_area, 0);
        end else begin
          int rem;
          rem = 40 - pad / 2;
          chk(frm_stored && !frm_overflow, "R6 stored pulse", {frm_stored, frm_overflow}, 2'b10);
          chk(words_left == 32'(rem), "R6 words charged", words_left, rem);
          chk(buf_addr == 32'h00011000 + 32'(base + pad), "R6 address advance", buf_addr, 32'h00011000 + base + pad);
          chk(last_pkt == (rem < 20), "R8 last flag", last_pkt, rem < 20);
          chk(mem_req == (rem < 20), "R9 auto fetch on last", mem_req, rem < 20);
          if (rem < 20) begin
            wait_idle();
            rd_m = rd_m + step;
            if (rd_m == ring_e) rd_m = 32;
          end
        end
        chk(rd_ptr == 16'(rd_m), "R2 read pointer track", rd_ptr, rd_m);
      end
    end

    // R2 wrap and R3 exhaust warning
    wide_mode = 1'b0;
    fill(2);
    wr_reg(3'd0, 16'h0020);
    wr_reg(3'd1, 16'h0040);
    wr_reg(3'd2, 16'h0038);
    wr_reg(3'd3, 16'h0020);
    do_fetch();
    chk(rd_ptr == 16'h0020, "R2 wrap to start", rd_ptr, 16'h0020);
    chk(sts_exhaust, "R3 exhaust raised", sts_exhaust, 1);

    // R5 acknowledge triggers fetch while set
    ack_exhaust = 1'b1; tick(); ack_exhaust = 1'b0;
    chk(mem_req, "R5 ack starts fetch", mem_req, 1);
    chk(!accept, "R11 accept low during fetch", accept, 0);
    wait_idle();
    chk(rd_ptr == 16'h0028, "R5 fetch advanced", rd_ptr, 16'h0028);
    chk(!sts_exhaust, "R3 exhaust cleared", sts_exhaust, 0);
    ack_exhaust = 1'b1; tick(); ack_exhaust = 1'b0;
    chk(!mem_req, "R5 ack while clear no fetch", mem_req, 0);
    tick();
    chk(rd_ptr == 16'h0028, "R5 ack while clear keeps pointer", rd_ptr, 16'h0028);

    // R9 stop, R11 ignore while stopped, R10 resume
    do_fetch();
    wr_reg(3'd3, rd_ptr);
    do_frame(70);
    chk(stopped && !accept, "R9 reception stops", {stopped, accept}, 2'b10);
    chk(!mem_req, "R9 no fetch when caught", mem_req, 0);
    chk(words_left == 3, "R6 words after big frame", words_left, 3);
    do_frame(1);
    tick();
    chk(words_left == 3 && !frm_stored && !frm_overflow, "R11 frame ignored while stopped", words_left, 3);
    chk(last_pkt, "R11 last flag untouched", last_pkt, 1);
    do_fetch();
    chk(!stopped && accept, "R10 fetch resumes", {stopped, accept}, 2'b01);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule